// File: doc/BRIEF.md
# Device error status and reporting

This block is a configuration-register slice for a serial-to-parallel bridge function. It holds a 16-bit device status word and the three error-message enable bits of the device control word. It watches event pulses from the datapath. These pulses cover non-posted requests being issued and completed, requests that no function claims, and error detections of three severity classes from any number of sources. From those pulses it keeps the status word current.

The status word mixes two kinds of bit. The first is a live indicator that stays high while any non-posted request is still waiting for its completion. The second is a set of sticky flags that record every detected error class and every unclaimed request. Each sticky flag stays set until software writes 1 to it. The flags latch whether or not the class is enabled for reporting. A separate gate, controlled by the per-class enable bits, decides whether a detection also produces a one-cycle message request on the matching output.

Software reaches both words through a 16-bit port with per-byte write enables. A select input picks the word. Reads are combinational and reflect register state in the same cycle.

Top module: `dev_err_status`

## Requirements
- R1: After reset both words read 0x0000 and all three message outputs are low.
- R2: Status bit 5 (pending) reads 1 in the cycle after the outstanding non-posted count becomes non-zero. It returns to 0 only after a completion has been seen for every issued request.
- R3: An issue pulse and a completion pulse in the same cycle leave the outstanding count, and so bit 5, unchanged.
- R4: An error pulse of class fatal, non-fatal or correctable, from any source, sets status bit 2, 1 or 0 respectively. This happens whatever the enable bits hold.
- R5: Writing 1 to status bits 3..0 (with byte enable 0 set) clears those bits. Writing 0 leaves them unchanged.
- R6: If hardware sets a status flag in the same cycle that software writes 1 to clear it, the flag reads 1 afterwards.
- R7: An unclaimed-request pulse sets status bit 3, which is cleared only by writing 1 to it.
- R8: Status bit 4 and bits 15..6 always read 0, and writes to them and to bit 5 have no effect. Control bits 15..3 always read 0.
- R9: Control bits 2..0 (fatal, non-fatal, correctable enable) are read/write with reset value 0. They are written only when byte enable 0 is set.
- R10: A message output pulses high for exactly one cycle, in the cycle after an error of its class, only if that class's enable bit was 1 when the error arrived. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Word select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte write enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected word |
| np_issue | input | 1 | A non-posted request was issued |
| np_done | input | 1 | A completion for a non-posted request arrived |
| req_unclaimed | input | 1 | A request arrived that no function claims |
| err_ev | input | N_SRC*3 | Per-source error pulses, bit 0 correctable, 1 non-fatal, 2 fatal |
| msg_req | output | 3 | Message requests, bit 0 correctable, 1 non-fatal, 2 fatal |

## Verification
The hardest case to reach from the ports is a collision between a hardware set and a software clear on the same flag in one cycle. The bench drives an error pulse and a write-1 of the same bit in the same cycle, then reads the bit back. A second hard case is a simultaneous issue and completion while requests are outstanding. The bench builds the count up first so that the collision happens at a non-zero count, and then drains it to show the count was neither lost nor inflated.

// File: rtl/dev_err_pkg.sv
package dev_err_pkg;
  localparam int CLS = 3;
  localparam int CLS_CORR = 0;
  localparam int CLS_NONFATAL = 1;
  localparam int CLS_FATAL = 2;
  localparam int ST_UR = 3;
  localparam int ST_PEND = 5;
  localparam logic [15:0] ST_W1C_MASK = 16'h000F;
  localparam logic [15:0] CTL_RW_MASK = 16'h0007;
  typedef logic [CLS-1:0] cls_t;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} sel_e;
endpackage

// File: rtl/np_tracker.sv
module np_tracker #(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic done,
  output logic pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (issue && !done && cnt_q != CNT_MAX)
      cnt_nxt = cnt_q + 1'b1;
    else if (done && !issue && cnt_q != '0)
      cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      pending <= (cnt_nxt != '0);
    end
  end

  // R3: simultaneous issue and completion keep the count
  a_r3_both_hold: assert property (@(posedge clk) disable iff (rst)
    (issue && done) |=> $stable(cnt_q));
  // R2: pending follows count across the register boundary
  a_r2_pend_live: assert property (@(posedge clk) disable iff (rst)
    (done && !issue && cnt_q == 1) |=> !pending);
endmodule

// File: rtl/src_merge.sv
module src_merge #(
  parameter int N_SRC = 2,
  parameter int CLS = 3
) (
  input  logic [N_SRC*CLS-1:0] ev_in,
  output logic [CLS-1:0]       ev_any
);
  always_comb begin
    ev_any = '0;
    for (int s = 0; s < N_SRC; s++)
      ev_any = ev_any | ev_in[s*CLS +: CLS];
  end
endmodule

// File: rtl/msg_gate.sv
module msg_gate #(
  parameter int CLS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CLS-1:0] ev,
  input  logic [CLS-1:0] en,
  output logic [CLS-1:0] msg
);
  for (genvar c = 0; c < CLS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst) msg[c] <= 1'b0;
      else     msg[c] <= ev[c] & en[c];
    end
    // R10: a disabled class never produces a message
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
      !en[c] |=> !msg[c]);
  end
endmodule

// File: rtl/dev_err_status.sv
module dev_err_status
  import dev_err_pkg::*;
#(
  parameter int N_SRC = 2,
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [1:0]         reg_be,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               np_issue,
  input  logic               np_done,
  input  logic               req_unclaimed,
  input  logic [N_SRC*3-1:0] err_ev,
  output logic [2:0]         msg_req
);
  logic [15:0] ctl_q;
  logic [15:0] st_q;
  logic        pend;
  cls_t        err_any;
  logic [15:0] byte_mask;
  logic [15:0] set_v;
  logic [15:0] clr_v;
  logic        wr_ctl;
  logic        wr_st;

  np_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .issue(np_issue), .done(np_done), .pending(pend)
  );

  src_merge #(.N_SRC(N_SRC), .CLS(CLS)) u_mrg (
    .ev_in(err_ev), .ev_any(err_any)
  );

  msg_gate #(.CLS(CLS)) u_msg (
    .clk(clk), .rst(rst), .ev(err_any), .en(ctl_q[CLS-1:0]), .msg(msg_req)
  );

  assign byte_mask = {{8{reg_be[1]}}, {8{reg_be[0]}}};
  assign wr_ctl    = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_st     = reg_wr && (reg_sel == SEL_STAT);
  assign set_v     = {12'h000, req_unclaimed, err_any};
  assign clr_v     = wr_st ? (reg_wdata & byte_mask) : 16'h0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      st_q  <= '0;
    end else begin
      if (wr_ctl)
        ctl_q <= (ctl_q & ~(CTL_RW_MASK & byte_mask)) |
                 (reg_wdata & CTL_RW_MASK & byte_mask);
      st_q <= ((st_q & ~clr_v) | set_v) & ST_W1C_MASK;
    end
  end

  always_comb begin
    if (reg_sel == SEL_STAT) begin
      reg_rdata = st_q;
      reg_rdata[ST_PEND] = pend;
    end else begin
      reg_rdata = ctl_q;
    end
  end

  // R6: a hardware set wins over a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (err_any[CLS_FATAL] && wr_st && reg_be[0] && reg_wdata[CLS_FATAL])
    |=> st_q[CLS_FATAL]);
  // R5: writing 0 keeps a set flag
  a_r5_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (st_q[ST_UR] && !(wr_st && reg_be[0] && reg_wdata[ST_UR])) |=> st_q[ST_UR]);
  // R8: reserved status bits read 0
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == SEL_STAT) |-> (reg_rdata[15:6] == 10'h0 && !reg_rdata[4]));
  // R9: control word never exposes more than its enables
  a_r9_ctl_width: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == SEL_CTRL) |-> (reg_rdata[15:3] == 13'h0));
  // R4: an error of a class always lands in its flag
  a_r4_latch: assert property (@(posedge clk) disable iff (rst)
    err_any[CLS_CORR] |=> st_q[CLS_CORR]);
endmodule

// File: tb/sim_dev_err_status.sv
module sim_dev_err_status;
  localparam int CLK_PER = 10;
  localparam int N_SRC = 2;

  logic clk = 1'b0;
  logic rst;
  logic reg_sel, reg_wr;
  logic [1:0] reg_be;
  logic [15:0] reg_wdata, reg_rdata;
  logic np_issue, np_done, req_unclaimed;
  logic [N_SRC*3-1:0] err_ev;
  logic [2:0] msg_req;
  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dev_err_status #(.N_SRC(N_SRC), .CNT_W(6)) u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .np_issue(np_issue),
    .np_done(np_done), .req_unclaimed(req_unclaimed), .err_ev(err_ev),
    .msg_req(msg_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = '0;
  endtask

  task automatic clear_all();
    wr(1'b1, 2'b11, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b0, v); chk("R1 ctrl", v, 16'h0000);
    rd(1'b1, v); chk("R1 status", v, 16'h0000);
    chk("R1 msg", {13'h0, msg_req}, 16'h0000);
  endtask

  task automatic t_pending();
    logic [15:0] v;
    for (int i = 0; i < 3; i++) begin np_issue = 1'b1; tick(); end
    np_issue = 1'b0;
    rd(1'b1, v); chk("R2 pending after issue", v & 16'h0020, 16'h0020);
    np_done = 1'b1; tick(); tick(); np_done = 1'b0;
    rd(1'b1, v); chk("R2 pending one left", v & 16'h0020, 16'h0020);
    np_issue = 1'b1; np_done = 1'b1; tick(); np_issue = 1'b0; np_done = 1'b0;
    rd(1'b1, v); chk("R3 same-cycle hold", v & 16'h0020, 16'h0020);
    np_done = 1'b1; tick(); np_done = 1'b0;
    rd(1'b1, v); chk("R3 drained after collision", v & 16'h0020, 16'h0000);
  endtask

  task automatic t_latch_masked();
    logic [15:0] v;
    err_ev = 6'b111_000; tick();
    chk("R10 disabled no msg", {13'h0, msg_req}, 16'h0000);
    err_ev = '0;
    rd(1'b1, v); chk("R4 flags from source 1", v, 16'h0007);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, v); chk("R5 write 0 keeps", v, 16'h0007);
    wr(1'b1, 2'b10, 16'h0001);
    rd(1'b1, v); chk("R5 clear needs byte 0", v, 16'h0007);
    wr(1'b1, 2'b01, 16'h0001);
    rd(1'b1, v); chk("R5 clear bit 0 only", v, 16'h0006);
    clear_all();
    rd(1'b1, v); chk("R5 clear all", v, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    err_ev = 6'b000_100;
    wr(1'b1, 2'b01, 16'h0004);
    err_ev = '0;
    rd(1'b1, v); chk("R6 set beats clear", v, 16'h0004);
    clear_all();
  endtask

  task automatic t_ur();
    logic [15:0] v;
    req_unclaimed = 1'b1; tick(); req_unclaimed = 1'b0;
    rd(1'b1, v); chk("R7 unclaimed sets bit 3", v, 16'h0008);
    wr(1'b1, 2'b01, 16'h0008);
    rd(1'b1, v); chk("R7 bit 3 cleared", v, 16'h0000);
  endtask

  task automatic t_rsvd_ctrl();
    logic [15:0] v;
    wr(1'b1, 2'b11, 16'hFFFF);
    rd(1'b1, v); chk("R8 status reserved", v, 16'h0000);
    wr(1'b0, 2'b11, 16'hFFFF);
    rd(1'b0, v); chk("R8 ctrl upper zero", v, 16'h0007);
    wr(1'b0, 2'b10, 16'h0000);
    rd(1'b0, v); chk("R9 byte 1 only ignored", v, 16'h0007);
    wr(1'b0, 2'b01, 16'h0005);
    rd(1'b0, v); chk("R9 ctrl write", v, 16'h0005);
  endtask

  task automatic t_msg();
    logic [15:0] v;
    err_ev = 6'b000_100; tick(); err_ev = '0;
    chk("R10 fatal msg", {13'h0, msg_req}, 16'h0004);
    tick();
    chk("R10 one cycle", {13'h0, msg_req}, 16'h0000);
    err_ev = 6'b010_000; tick(); err_ev = '0;
    chk("R10 nonfatal disabled", {13'h0, msg_req}, 16'h0000);
    err_ev = 6'b001_000; tick(); err_ev = '0;
    chk("R10 correctable enabled", {13'h0, msg_req}, 16'h0001);
    rd(1'b1, v); chk("R4 all flags set", v, 16'h0007);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_sel = 1'b0; reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    np_issue = 1'b0; np_done = 1'b0; req_unclaimed = 1'b0; err_ev = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    t_reset();
    t_pending();
    t_latch_masked();
    t_w1c();
    t_set_wins();
    t_ur();
    t_rsvd_ctrl();
    t_msg();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule